// File: doc/BRIEF.md
# Framebuffer Window Line Fetcher

This block reads a visible window out of a wider virtual framebuffer held in memory and streams the fetched 32-bit words into an internal pixel FIFO. Software programs a base byte address, the number of words in one visible line, the number of bytes to step over at the end of each line, the number of words in one frame, a burst length and a sub-word pixel bit offset. The fetcher walks the window one line at a time. It cuts each burst so that a burst never crosses a line end or a frame end. It issues word-aligned burst reads on a simple request/grant port and wraps back to the base address once the last word of a frame has been requested.

A new burst is requested only when the FIFO has room for it and for a safety margin. The threshold is the FIFO depth minus twice the burst length minus three. Configuration changes go through a shadow copy. The copy is loaded when the fetcher is enabled. While it runs, the copy is reloaded only when an update has been requested and the last burst of the current frame is granted, so a frame never mixes two settings. The pixel side pops words from the FIFO head. Popping an empty FIFO raises a sticky underflow flag. A response beat that arrives at a full FIFO is dropped and raises a sticky overwrite flag.

Top module: `fb_line_fetch`

## Requirements
- R1: While reset is held, `memReq`, `busy`, `pixValid`, `underflow` and `overwrite` are all low.
- R2: The first request after enable, and the first request after every reload, uses the base address with its two low bits cleared.
- R3: Each request's `memLenM1` is the word count minus one. The word count is the smallest of (`cfgBurstM1`+1), the words left in the current line and the words left in the frame.
- R4: After the last word of a line, the next request address is that line's start plus 4×`cfgLineWords` plus `cfgSkipBytes` with its two low bits cleared.
- R5: Once `cfgFrameWords` words of a frame have been requested, the next request starts again at the base address.
- R6: A new request is raised only if FIFO occupancy is at or below DEPTH − (2×(`cfgBurstM1`+1) + 3). Popping words below that level lets requests resume.
- R7: A `cfgUpdate` pulse takes effect when the last burst of the current frame is granted. Until then, the remaining requests of that frame use the old settings and `pixOffset` keeps its old value. Without a pulse, changing the configuration inputs has no effect while running.
- R8: Words leave the FIFO in the order the response beats delivered them, with `pixData` showing the head word while `pixValid` is high.
- R9: A pop while the FIFO is empty sets `underflow`, which stays high until `clrFlags` is pulsed.
- R10: A response beat that arrives while the FIFO holds DEPTH words is discarded and sets `overwrite`, which stays high until `clrFlags` is pulsed.
- R11: `busy` is high whenever `enable` is high, and after disable it stays high until the last beat of a granted burst has arrived.
- R12: A raised request stays up until granted while enabled. If `enable` falls before the grant, the request is withdrawn one cycle later and no further request is raised while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the fetcher |
| cfgUpdate | input | 1 | One-cycle pulse requesting a reload at the next frame boundary |
| cfgBase | input | ADDR_W | Window start byte address |
| cfgLineWords | input | LINE_W | Visible words per line (nonzero) |
| cfgSkipBytes | input | SKIP_W | Bytes stepped over after each line |
| cfgFrameWords | input | FRAME_W | Words per frame (nonzero) |
| cfgBurstM1 | input | BURST_W | Burst length minus one |
| cfgPixOffset | input | 5 | Bit offset of the first pixel in the first word |
| memReq | output | 1 | Burst read request |
| memAddr | output | ADDR_W | Word-aligned burst byte address |
| memLenM1 | output | BURST_W | Burst words minus one |
| memGnt | input | 1 | Request accepted |
| memRdValid | input | 1 | Response beat valid |
| memRdData | input | DATA_W | Response beat data |
| pixPop | input | 1 | Pop the FIFO head |
| pixData | output | DATA_W | FIFO head word |
| pixValid | output | 1 | FIFO is not empty |
| pixOffset | output | 5 | Pixel bit offset in force for the frame being fetched |
| clrFlags | input | 1 | Clear both sticky flags |
| underflow | output | 1 | Sticky empty-pop flag |
| overwrite | output | 1 | Sticky full-write flag |
| busy | output | 1 | Enabled or a burst still outstanding |

## Verification
A request is raised in the cycle after the enable reload (two edges after `enable` rises), and every later request appears one edge after the FIFO check passes. The grant is taken on the edge where `memReq` and `memGnt` meet, so the address and `pixOffset` that follow are visible from the next half-cycle. FIFO flags and `pixValid` change on the edge that takes the beat or the pop. `busy` falls on the edge that takes the last beat once `enable` is low. The bench drives at falling edges and samples at falling edges, so every result is read at least half a cycle after the edge that produced it. Request addresses and lengths are logged at the grant and compared once the run has stopped.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  // Strobes from the control FSM to the address datapath.
  typedef struct packed {
    logic reload;   // load shadow configuration and restart at base
    logic advance;  // current burst granted: step the read position
  } fbfStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RESP = 2'd2
  } fbfStateT;

endpackage

// File: rtl/fbf_fifo.sv
module fbf_fifo #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdPop,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [CNT_W-1:0]  occ,
  input  logic              clrFlags,
  output logic              underflow,
  output logic              overwrite
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              isFull, isEmpty, doPush, doPop;

  assign isFull  = (count == CNT_W'(DEPTH));
  assign isEmpty = (count == '0);
  assign doPush  = wrValid && !isFull;
  assign doPop   = rdPop && !isEmpty;

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      underflow <= 1'b0;
      overwrite <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= rdPtr + PTR_W'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      underflow <= (underflow && !clrFlags) || (rdPop && isEmpty);
      overwrite <= (overwrite && !clrFlags) || (wrValid && isFull);
    end
  end

  assign rdData  = store[rdPtr];
  assign rdValid = !isEmpty;
  assign occ     = count;

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CNT_W'(DEPTH)); // R10
  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && rdValid && occ == CNT_W'(DEPTH)) |=> overwrite); // R10
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !clrFlags) |=> underflow); // R9
  AST_EMPTY_POP_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (rdPop && !rdValid) |=> underflow); // R9

endmodule

// File: rtl/fbf_addr_path.sv
module fbf_addr_path
  import fbf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LINE_W  = 12,
  parameter int SKIP_W  = 16,
  parameter int FRAME_W = 20,
  parameter int BURST_W = 4,
  parameter int DEPTH   = 512,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  fbfStrobeT          strobe,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [LINE_W-1:0]  cfgLineWords,
  input  logic [SKIP_W-1:0]  cfgSkipBytes,
  input  logic [FRAME_W-1:0] cfgFrameWords,
  input  logic [BURST_W-1:0] cfgBurstM1,
  input  logic [4:0]         cfgPixOffset,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [BURST_W-1:0] reqLenM1,
  output logic               lastOfFrame,
  output logic [CNT_W-1:0]   thresh,
  output logic [4:0]         pixOffset
);

  // Shadow configuration, loaded only on reload.
  logic [ADDR_W-1:0]  shBase;
  logic [LINE_W-1:0]  shLine;
  logic [SKIP_W-1:0]  shSkip;
  logic [FRAME_W-1:0] shFrame;
  logic [BURST_W-1:0] shBurst;
  logic [4:0]         shOffset;

  // Read position.
  logic [ADDR_W-1:0]  lineStart;
  logic [LINE_W-1:0]  wordInLine;
  logic [FRAME_W-1:0] frameDone;

  logic [FRAME_W-1:0] burstWords, lineRemain, frameRemain, chunk, firstMin;
  logic [ADDR_W-1:0]  lineStep, alignedBase;
  logic               lineEnd;

  always_comb begin
    burstWords  = FRAME_W'(shBurst) + FRAME_W'(1);
    lineRemain  = FRAME_W'(shLine - wordInLine);
    frameRemain = shFrame - frameDone;
    firstMin    = (burstWords < lineRemain) ? burstWords : lineRemain;
    chunk       = (firstMin < frameRemain) ? firstMin : frameRemain;
    lineEnd     = (chunk == lineRemain);
    lastOfFrame = (chunk == frameRemain);
    reqLenM1    = BURST_W'(chunk - FRAME_W'(1));
    reqAddr     = lineStart + (ADDR_W'(wordInLine) << 2);
    lineStep    = (ADDR_W'(shLine) << 2) + ADDR_W'({shSkip[SKIP_W-1:2], 2'b00});
    alignedBase = {cfgBase[ADDR_W-1:2], 2'b00};
    thresh      = CNT_W'(DEPTH - 3) - (CNT_W'(burstWords) << 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shBase     <= '0;
      shLine     <= '0;
      shSkip     <= '0;
      shFrame    <= '0;
      shBurst    <= '0;
      shOffset   <= '0;
      lineStart  <= '0;
      wordInLine <= '0;
      frameDone  <= '0;
    end else if (strobe.reload) begin
      shBase     <= alignedBase;
      shLine     <= cfgLineWords;
      shSkip     <= cfgSkipBytes;
      shFrame    <= cfgFrameWords;
      shBurst    <= cfgBurstM1;
      shOffset   <= cfgPixOffset;
      lineStart  <= alignedBase;
      wordInLine <= '0;
      frameDone  <= '0;
    end else if (strobe.advance) begin
      if (lastOfFrame) begin
        lineStart  <= shBase;
        wordInLine <= '0;
        frameDone  <= '0;
      end else if (lineEnd) begin
        lineStart  <= lineStart + lineStep;
        wordInLine <= '0;
        frameDone  <= frameDone + chunk;
      end else begin
        wordInLine <= wordInLine + LINE_W'(chunk);
        frameDone  <= frameDone + chunk;
      end
    end
  end

  assign pixOffset = shOffset;

  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (reqLenM1 <= shBurst)); // R3
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (reqAddr[1:0] == 2'b00)); // R2
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.reload |=> $stable(shBase) && $stable(shOffset)); // R7

endmodule

// File: rtl/fbf_ctrl.sv
module fbf_ctrl
  import fbf_pkg::*;
#(
  parameter int BURST_W = 4,
  parameter int CNT_W   = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               cfgUpdate,
  input  logic               memGnt,
  input  logic               memRdValid,
  input  logic [BURST_W-1:0] reqLenM1,
  input  logic               lastOfFrame,
  input  logic [CNT_W-1:0]   occ,
  input  logic [CNT_W-1:0]   thresh,
  output fbfStrobeT          strobe,
  output logic               memReq,
  output logic               busy
);

  fbfStateT           state;
  logic               running;
  logic               pending;
  logic [BURST_W-1:0] beatCnt;
  logic [BURST_W-1:0] lenHold;
  logic               granted;

  assign granted        = (state == ST_REQ) && memGnt;
  assign strobe.advance = granted;
  assign strobe.reload  = ((state == ST_IDLE) && enable && !running)
                       || (granted && lastOfFrame && pending);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      running <= 1'b0;
      pending <= 1'b0;
      beatCnt <= '0;
      lenHold <= '0;
    end else begin
      pending <= (pending && !strobe.reload) || cfgUpdate;
      case (state)
        ST_IDLE: begin
          if (!enable) begin
            running <= 1'b0;
          end else if (!running) begin
            running <= 1'b1;
          end else if (occ <= thresh) begin
            state <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (memGnt) begin
            state   <= ST_RESP;
            beatCnt <= '0;
            lenHold <= reqLenM1;
          end else if (!enable) begin
            state <= ST_IDLE;
          end
        end
        ST_RESP: begin
          if (memRdValid) begin
            if (beatCnt == lenHold) state <= ST_IDLE;
            else                    beatCnt <= beatCnt + BURST_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memReq = (state == ST_REQ);
  assign busy   = enable || (state != ST_IDLE);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt && enable) |=> memReq); // R12
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !memReq) |=> !memReq); // R12
  AST_REQ_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> ($past(occ) <= $past(thresh))); // R6
  AST_BUSY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> busy); // R11

endmodule

// File: rtl/fb_line_fetch.sv
module fb_line_fetch
  import fbf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_W     = 12,
  parameter int SKIP_W     = 16,
  parameter int FRAME_W    = 20,
  parameter int BURST_W    = 4,
  parameter int FIFO_DEPTH = 512,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               cfgUpdate,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [LINE_W-1:0]  cfgLineWords,
  input  logic [SKIP_W-1:0]  cfgSkipBytes,
  input  logic [FRAME_W-1:0] cfgFrameWords,
  input  logic [BURST_W-1:0] cfgBurstM1,
  input  logic [4:0]         cfgPixOffset,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [BURST_W-1:0] memLenM1,
  input  logic               memGnt,
  input  logic               memRdValid,
  input  logic [DATA_W-1:0]  memRdData,
  input  logic               pixPop,
  output logic [DATA_W-1:0]  pixData,
  output logic               pixValid,
  output logic [4:0]         pixOffset,
  input  logic               clrFlags,
  output logic               underflow,
  output logic               overwrite,
  output logic               busy
);

  fbfStrobeT          strobe;
  logic [BURST_W-1:0] reqLenM1;
  logic               lastOfFrame;
  logic [CNT_W-1:0]   occ, thresh;

  fbf_ctrl #(
    .BURST_W(BURST_W),
    .CNT_W  (CNT_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .cfgUpdate  (cfgUpdate),
    .memGnt     (memGnt),
    .memRdValid (memRdValid),
    .reqLenM1   (reqLenM1),
    .lastOfFrame(lastOfFrame),
    .occ        (occ),
    .thresh     (thresh),
    .strobe     (strobe),
    .memReq     (memReq),
    .busy       (busy)
  );

  fbf_addr_path #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .SKIP_W (SKIP_W),
    .FRAME_W(FRAME_W),
    .BURST_W(BURST_W),
    .DEPTH  (FIFO_DEPTH)
  ) path_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgBase      (cfgBase),
    .cfgLineWords (cfgLineWords),
    .cfgSkipBytes (cfgSkipBytes),
    .cfgFrameWords(cfgFrameWords),
    .cfgBurstM1   (cfgBurstM1),
    .cfgPixOffset (cfgPixOffset),
    .reqAddr      (memAddr),
    .reqLenM1     (reqLenM1),
    .lastOfFrame  (lastOfFrame),
    .thresh       (thresh),
    .pixOffset    (pixOffset)
  );

  assign memLenM1 = reqLenM1;

  fbf_fifo #(
    .DEPTH (FIFO_DEPTH),
    .DATA_W(DATA_W)
  ) fifo_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (memRdValid),
    .wrData   (memRdData),
    .rdPop    (pixPop),
    .rdData   (pixData),
    .rdValid  (pixValid),
    .occ      (occ),
    .clrFlags (clrFlags),
    .underflow(underflow),
    .overwrite(overwrite)
  );

endmodule

// File: tb/fb_line_fetch_tb_top.sv
module fb_line_fetch_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN;
  logic        enable, cfgUpdate, clrFlags;
  logic [31:0] cfgBase;
  logic [11:0] cfgLineWords;
  logic [15:0] cfgSkipBytes;
  logic [19:0] cfgFrameWords;
  logic [3:0]  cfgBurstM1;
  logic [4:0]  cfgPixOffset;
  logic        memReq, memGnt, memRdValid;
  logic [31:0] memAddr, memRdData, pixData;
  logic [3:0]  memLenM1;
  logic        pixPop, pixValid, underflow, overwrite, busy;
  logic [4:0]  pixOffset;

  always #2.5 clk = ~clk;

  fb_line_fetch #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgUpdate(cfgUpdate),
    .cfgBase(cfgBase), .cfgLineWords(cfgLineWords), .cfgSkipBytes(cfgSkipBytes),
    .cfgFrameWords(cfgFrameWords), .cfgBurstM1(cfgBurstM1), .cfgPixOffset(cfgPixOffset),
    .memReq(memReq), .memAddr(memAddr), .memLenM1(memLenM1), .memGnt(memGnt),
    .memRdValid(memRdValid), .memRdData(memRdData), .pixPop(pixPop),
    .pixData(pixData), .pixValid(pixValid), .pixOffset(pixOffset),
    .clrFlags(clrFlags), .underflow(underflow), .overwrite(overwrite), .busy(busy)
  );

  // Stimulus/expected vectors: configuration and first five requests.
  localparam logic [31:0] ROW_BASE  [4] = '{32'h1003, 32'h2000, 32'h0300, 32'h4000};
  localparam logic [11:0] ROW_LINE  [4] = '{12'd8, 12'd6, 12'd4, 12'd5};
  localparam logic [15:0] ROW_SKIP  [4] = '{16'd16, 16'd8, 16'd6, 16'd0};
  localparam logic [19:0] ROW_FRAME [4] = '{20'd32, 20'd12, 20'd10, 20'd5};
  localparam logic [3:0]  ROW_BM1   [4] = '{4'd7, 4'd3, 4'd7, 4'd15};
  localparam logic [31:0] EXP_ADDR [4][5] = '{
    '{32'h1000, 32'h1030, 32'h1060, 32'h1090, 32'h1000},
    '{32'h2000, 32'h2010, 32'h2020, 32'h2030, 32'h2000},
    '{32'h0300, 32'h0314, 32'h0328, 32'h0300, 32'h0314},
    '{32'h4000, 32'h4000, 32'h4000, 32'h4000, 32'h4000}};
  localparam logic [3:0] EXP_LEN [4][5] = '{
    '{4'd7, 4'd7, 4'd7, 4'd7, 4'd7},
    '{4'd3, 4'd1, 4'd3, 4'd1, 4'd3},
    '{4'd3, 4'd3, 4'd1, 4'd3, 4'd3},
    '{4'd4, 4'd4, 4'd4, 4'd4, 4'd4}};
  // index of the first request of the second frame in each row
  localparam int WRAP_IDX [4] = '{4, 4, 3, 1};

  int checks = 0;
  int fails  = 0;

  // memory responder state
  logic        respOn;
  int          beatGap;
  int          reqCount;
  logic        respIdle;
  int          injReq, injDone;
  logic [31:0] logAddr [256];
  logic [3:0]  logLen  [256];
  logic [31:0] expMem  [4096];
  int          expWr;

  // pixel consumer state
  logic        popOn, cmpOn, popperPop, forcePop;
  int          popReq, popDone, expRd, orderErr;
  logic [31:0] lastPop;

  assign pixPop = popperPop | forcePop;

  task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  initial begin : responder
    logic [31:0] a;
    int n;
    memGnt = 1'b0; memRdValid = 1'b0; memRdData = '0;
    respIdle = 1'b1; reqCount = 0; injDone = 0; expWr = 0;
    forever begin
      @(negedge clk);
      if (respOn && memReq) begin
        respIdle = 1'b0;
        a = memAddr;
        n = int'(memLenM1);
        if (reqCount < 256) begin
          logAddr[reqCount] = a;
          logLen[reqCount]  = memLenM1;
        end
        reqCount++;
        memGnt = 1'b1;
        @(negedge clk);
        memGnt = 1'b0;
        repeat (beatGap) @(negedge clk);
        for (int i = 0; i <= n; i++) begin
          memRdValid = 1'b1;
          memRdData  = (a >> 2) + 32'(i);
          expMem[expWr % 4096] = memRdData;
          expWr++;
          @(negedge clk);
        end
        memRdValid = 1'b0;
        respIdle   = 1'b1;
      end else if (injDone < injReq) begin
        memRdValid = 1'b1;
        memRdData  = 32'hA000 + 32'(injDone);
        injDone++;
        @(negedge clk);
        memRdValid = 1'b0;
      end
    end
  end

  initial begin : popper
    popperPop = 1'b0; popDone = 0; expRd = 0; orderErr = 0; lastPop = '0;
    forever begin
      @(negedge clk);
      popperPop = 1'b0;
      if (pixValid && (popOn || popDone < popReq)) begin
        popperPop = 1'b1;
        lastPop   = pixData;
        if (!popOn) popDone++;
        if (cmpOn) begin
          if (expRd >= expWr || expMem[expRd % 4096] != pixData) orderErr++;
          expRd++;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  task automatic setCfg(input logic [31:0] b, input logic [11:0] l, input logic [15:0] s,
                        input logic [19:0] f, input logic [3:0] bm, input logic [4:0] po);
    cfgBase = b; cfgLineWords = l; cfgSkipBytes = s;
    cfgFrameWords = f; cfgBurstM1 = bm; cfgPixOffset = po;
  endtask

  task automatic stopAndDrain();
    @(negedge clk);
    enable = 1'b0;
    wait (!busy && respIdle);
    repeat (20) @(negedge clk);
  endtask

  initial begin : main
    int start;
    string tag;
    rstN = 1'b0; enable = 1'b0; cfgUpdate = 1'b0; clrFlags = 1'b0; forcePop = 1'b0;
    respOn = 1'b1; beatGap = 0; injReq = 0; popOn = 1'b1; cmpOn = 1'b1; popReq = 0;
    setCfg(32'h0, 12'd1, 16'd0, 20'd1, 4'd0, 5'd0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(memReq == 1'b0,    "R1 memReq in reset",    32'(memReq), 0);
    chk(busy == 1'b0,      "R1 busy in reset",      32'(busy), 0);
    chk(pixValid == 1'b0,  "R1 pixValid in reset",  32'(pixValid), 0);
    chk(underflow == 1'b0, "R1 underflow in reset", 32'(underflow), 0);
    chk(overwrite == 1'b0, "R1 overwrite in reset", 32'(overwrite), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R2 first address, R3 lengths, R4 line step, R5 frame wrap
    for (int r = 0; r < 4; r++) begin
      setCfg(ROW_BASE[r], ROW_LINE[r], ROW_SKIP[r], ROW_FRAME[r], ROW_BM1[r], 5'(r));
      start = reqCount;
      enable = 1'b1;
      wait (reqCount == start + 5);
      stopAndDrain();
      for (int k = 0; k < 5; k++) begin
        if (k == 0)                tag = "R2";
        else if (k == WRAP_IDX[r]) tag = "R5";
        else                       tag = "R4";
        chk(logAddr[start+k] == EXP_ADDR[r][k],
            $sformatf("%s row %0d req %0d address", tag, r, k), logAddr[start+k], EXP_ADDR[r][k]);
        chk(logLen[start+k] == EXP_LEN[r][k],
            $sformatf("R3 row %0d req %0d length", r, k), 32'(logLen[start+k]), 32'(EXP_LEN[r][k]));
      end
    end

    // R6: threshold with no consumer, DEPTH 64 and burst 8 -> threshold 45
    popOn = 1'b0;
    setCfg(32'h8000, 12'd64, 16'd0, 20'd1000, 4'd7, 5'd0);
    start = reqCount;
    enable = 1'b1;
    repeat (120) @(negedge clk);
    chk(reqCount - start == 6, "R6 bursts before threshold stops", 32'(reqCount - start), 6);
    chk(memReq == 1'b0, "R6 no request above threshold", 32'(memReq), 0);
    popReq = popReq + 3;
    repeat (40) @(negedge clk);
    chk(reqCount - start == 7, "R6 request resumes at threshold", 32'(reqCount - start), 7);
    popOn = 1'b1;
    stopAndDrain();

    // R7: update applied at the frame boundary only
    beatGap = 4;
    setCfg(32'h5000, 12'd4, 16'd0, 20'd8, 4'd3, 5'd3);
    start = reqCount;
    enable = 1'b1;
    wait (reqCount == start + 1);
    @(negedge clk);
    cfgBase = 32'h6000; cfgPixOffset = 5'd9; cfgUpdate = 1'b1;
    @(negedge clk);
    cfgUpdate = 1'b0;
    chk(pixOffset == 5'd3, "R7 offset unchanged mid-frame", 32'(pixOffset), 3);
    wait (reqCount == start + 3);
    stopAndDrain();
    chk(logAddr[start+1] == 32'h5010, "R7 old frame finishes on old base", logAddr[start+1], 32'h5010);
    chk(logAddr[start+2] == 32'h6000, "R7 new frame starts on new base", logAddr[start+2], 32'h6000);
    chk(pixOffset == 5'd9, "R7 offset switched at frame boundary", 32'(pixOffset), 9);
    beatGap = 0;

    // R10 and R9: overwrite on full, underflow on empty, sticky until cleared
    popOn = 1'b0; cmpOn = 1'b0;
    chk(underflow == 1'b0 && overwrite == 1'b0, "R9 flags clear before test",
        32'({underflow, overwrite}), 0);
    injReq = injReq + DEPTH + 1;
    wait (injDone == injReq);
    repeat (2) @(negedge clk);
    chk(overwrite == 1'b1, "R10 overwrite set by write to full FIFO", 32'(overwrite), 1);
    chk(underflow == 1'b0, "R9 no underflow while filling", 32'(underflow), 0);
    popReq = popReq + DEPTH;
    wait (popDone == popReq);
    repeat (2) @(negedge clk);
    chk(pixValid == 1'b0, "R10 extra word dropped", 32'(pixValid), 0);
    chk(lastPop == 32'hA000 + DEPTH - 1, "R10 last stored word", lastPop, 32'hA000 + DEPTH - 1);
    forcePop = 1'b1;
    @(negedge clk);
    forcePop = 1'b0;
    repeat (5) @(negedge clk);
    chk(underflow == 1'b1, "R9 underflow sticky after empty pop", 32'(underflow), 1);
    chk(overwrite == 1'b1, "R10 overwrite still sticky", 32'(overwrite), 1);
    clrFlags = 1'b1;
    @(negedge clk);
    clrFlags = 1'b0;
    @(negedge clk);
    chk(underflow == 1'b0 && overwrite == 1'b0, "R9 flags cleared", 32'({underflow, overwrite}), 0);
    popOn = 1'b1; cmpOn = 1'b1;

    // R12: ungranted request withdrawn on disable
    respOn = 1'b0;
    setCfg(32'h7002, 12'd8, 16'd0, 20'd16, 4'd3, 5'd0);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    chk(memReq == 1'b1, "R12 request held while waiting for grant", 32'(memReq), 1);
    enable = 1'b0;
    @(negedge clk);
    chk(memReq == 1'b0, "R12 request withdrawn after disable", 32'(memReq), 0);
    chk(busy == 1'b0, "R11 idle after withdrawn request", 32'(busy), 0);

    // R2 restart at base, then R11 busy across a disable with a burst in flight
    respOn = 1'b1; beatGap = 6;
    start = reqCount;
    enable = 1'b1;
    wait (reqCount == start + 1);
    @(negedge clk);
    enable = 1'b0;
    chk(logAddr[start] == 32'h7000, "R2 re-enable restarts at aligned base", logAddr[start], 32'h7000);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R11 busy with burst outstanding", 32'(busy), 1);
    wait (respIdle);
    chk(busy == 1'b0, "R11 busy drops after last beat", 32'(busy), 0);
    repeat (20) @(negedge clk);
    chk(memReq == 1'b0, "R12 no request while disabled", 32'(memReq), 0);

    // R8: every popped word matched the delivery order
    chk(orderErr == 0 && expRd == expWr, "R8 FIFO order and count", 32'(orderErr), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule